// File: doc/BRIEF.md
# Deserialized Word Rotation Aligner

The aligner sits directly behind a one-to-seven deserializer. Each parallel word it receives holds seven serial bits, but the frame boundary chosen by the receiver need not match the one the transmitter used, so the transmitted most significant bit can land anywhere in the received word. The block keeps the previous valid word and forms a fourteen-bit window with the current one. It then picks the seven-bit slice that restores the transmitted order, so that the first serial bit of every frame appears in bit 6 of the output.

The slice offset comes from one of two sources. In static mode a configuration value supplies the offset directly and no training takes place. In training mode the far end sends a known seven-bit word. The block tries each of the seven offsets in turn until one of them matches for a run of consecutive words, then reports lock. While training is still requested it keeps watching for drift: a short run of mismatches drops lock and starts the search again. Training is meant for start-up and for recovery after temperature or supply changes.

Top module: `rot_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs become zero after that edge: `out_word`, `rot_used`, `out_valid`, `locked` and `search_err`.
- R2: On each edge where `in_valid` is high, `out_word` takes bits [k+6:k] of the fourteen-bit value {previous valid word, current `in_word`}, and `rot_used` takes k, where k is the offset in use. The previous word starts at zero after reset. When `in_valid` is low, `out_word` and `rot_used` hold their values.
- R3: With `mode_train` = 0 (static), k is `static_rot`, and a value of 7 is used as 6. `out_valid` equals `in_valid` from the preceding edge. `locked` and `search_err` are 0, and the search restarts at offset 0.
- R4: With `mode_train` = 1 and `train_req` = 1, each valid word compares the slice at the candidate offset with the training word (default 7'b1001011). While unlocked, a mismatch clears the match run and advances the candidate by one, with 6 wrapping to 0.
- R5: `locked` rises on the edge of the 8th consecutive matching valid training word at one candidate.
- R6: In training mode, `out_valid` equals `in_valid` AND `locked`, both taken as they were before the edge, so it is delayed by one cycle.
- R7: `search_err` is set by a mismatch at candidate 6 while unlocked. It is cleared when lock is gained, and the search continues while it is set.
- R8: While locked, 4 consecutive mismatching valid training words clear `locked` and return the candidate to 0. A match resets that mismatch run.
- R9: In training mode with `train_req` = 0, words of any content leave `locked`, `search_err` and the offset in use unchanged.
- R10: A received order of 2,1,0,6,5,4,3 (the transmitted MSB at received bit 3), trained with the training word, locks at `rot_used` = 4 and then outputs the training word itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| in_word | input | 7 | Raw word from the deserializer |
| in_valid | input | 1 | `in_word` carries a new word |
| mode_train | input | 1 | 0 = static offset, 1 = trained offset |
| static_rot | input | 3 | Offset used in static mode (7 is used as 6) |
| train_req | input | 1 | Incoming words are training words |
| out_word | output | 7 | Aligned word, transmitted MSB in bit 6 |
| out_valid | output | 1 | `out_word` holds a new aligned word |
| rot_used | output | 3 | Offset that produced `out_word` |
| locked | output | 1 | Training found a stable offset |
| search_err | output | 1 | A full sweep finished without lock |

## Verification
The bench builds deserializer streams with every true rotation from random transmitted words and checks that each static offset recovers the transmitted word. This would catch a slice taken in the wrong half or the wrong direction of the window. Training cases check the exact edge on which lock appears: a run counter that is off by one locks a word early or late. The bench moves the link rotation after lock to check that lock drops after the fourth mismatch and the search starts again at offset 0. Garbage sent with training not requested must leave lock alone, and a stream that can never match must raise the sweep error without stopping the search.

// File: rtl/rot_align_pkg.sv
package rot_align_pkg;

    localparam int FRAME_W = 7;
    localparam int OFF_W   = $clog2(FRAME_W);

    typedef enum logic {
        ALIGN_STATIC = 1'b0,
        ALIGN_TRAIN  = 1'b1
    } align_mode_e;

    typedef enum logic {
        PH_HUNT = 1'b0,
        PH_HELD = 1'b1
    } search_phase_e;

    typedef struct packed {
        logic [FRAME_W-1:0] word;
        logic [OFF_W-1:0]   rot;
        logic               valid;
    } aligned_t;

    // Offsets beyond the last legal slice saturate to it.
    function automatic logic [OFF_W-1:0] clamp_off(input logic [OFF_W-1:0] o);
        if (o > OFF_W'(FRAME_W - 1))
            return OFF_W'(FRAME_W - 1);
        return o;
    endfunction

endpackage

// File: rtl/rot_window.sv
module rot_window
    import rot_align_pkg::*;
#(
    parameter int W  = FRAME_W,
    parameter int OW = OFF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  in_word,
    input  logic          in_valid,
    input  logic [OW-1:0] sel,
    output logic [W-1:0]  slice
);

    localparam int WIN_W = 2 * W;

    logic [W-1:0]     prev_q;
    logic [WIN_W-1:0] win;
    logic [W-1:0]     taps [W];

    assign win = {prev_q, in_word};

    for (genvar k = 0; k < W; k++) begin : g_tap
        assign taps[k] = win[k +: W];
    end

    always_comb begin
        slice = '0;
        for (int k = 0; k < W; k++) begin
            if (sel == OW'(k))
                slice = taps[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= '0;
        else if (in_valid)
            prev_q <= in_word;
    end

endmodule

// File: rtl/rot_search.sv
module rot_search
    import rot_align_pkg::*;
#(
    parameter int           W          = FRAME_W,
    parameter int           OW         = OFF_W,
    parameter int           LOCK_RUN   = 8,
    parameter int           LOSS_RUN   = 4,
    parameter logic [W-1:0] TRAIN_WORD = 7'b1001011
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic          in_valid,
    input  logic          train_req,
    input  logic [W-1:0]  slice,
    output logic [OW-1:0] cand,
    output logic          locked,
    output logic          err
);

    localparam int RUN_W  = $clog2(LOCK_RUN + 1);
    localparam int MISS_W = $clog2(LOSS_RUN + 1);

    typedef struct packed {
        search_phase_e      phase;
        logic [OW-1:0]      cand;
        logic [RUN_W-1:0]   run;
        logic [MISS_W-1:0]  miss;
        logic               err;
    } srch_t;

    localparam srch_t SRCH_IDLE = '{PH_HUNT, '0, '0, '0, 1'b0};

    srch_t cur_q, nxt;
    logic  hit;

    assign hit = (slice == TRAIN_WORD);

    always_comb begin
        nxt = cur_q;
        if (!active) begin
            nxt = SRCH_IDLE;
        end else if (in_valid && train_req) begin
            if (cur_q.phase == PH_HUNT) begin
                if (hit) begin
                    if (cur_q.run == RUN_W'(LOCK_RUN - 1)) begin
                        nxt.phase = PH_HELD;
                        nxt.run   = '0;
                        nxt.miss  = '0;
                        nxt.err   = 1'b0;
                    end else begin
                        nxt.run = cur_q.run + 1'b1;
                    end
                end else begin
                    nxt.run = '0;
                    if (cur_q.cand == OW'(W - 1)) begin
                        nxt.cand = '0;
                        nxt.err  = 1'b1;
                    end else begin
                        nxt.cand = cur_q.cand + 1'b1;
                    end
                end
            end else begin
                if (hit) begin
                    nxt.miss = '0;
                end else if (cur_q.miss == MISS_W'(LOSS_RUN - 1)) begin
                    nxt = SRCH_IDLE;
                end else begin
                    nxt.miss = cur_q.miss + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_q <= SRCH_IDLE;
        else
            cur_q <= nxt;
    end

    assign cand   = cur_q.cand;
    assign locked = (cur_q.phase == PH_HELD);
    assign err    = cur_q.err;

    // R5: lock is only ever gained from a valid training word
    a_r5_lock_from_training: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(in_valid && train_req && active));

    // R7: the sweep error never coexists with lock
    a_r7_err_only_unlocked: assert property (@(posedge clk) disable iff (rst)
        locked |-> !err);

    // R8: losing lock in training mode restarts the sweep at offset 0
    a_r8_loss_restarts: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && $past(active)) |-> (cand == '0));

    // R9: no training request, no change to the search state
    a_r9_hold_without_request: assert property (@(posedge clk) disable iff (rst)
        (active && !train_req) |=> ($stable(locked) && $stable(cand) && $stable(err)));

endmodule

// File: rtl/rot_outreg.sv
module rot_outreg
    import rot_align_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] slice,
    input  logic [OFF_W-1:0]   sel,
    input  logic               in_valid,
    input  logic               pass,
    output aligned_t           q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.valid <= in_valid && pass;
            if (in_valid) begin
                q.word <= slice;
                q.rot  <= sel;
            end
        end
    end

    // R2: word and offset only move on a valid input
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(q.word) && $stable(q.rot)));

endmodule

// File: rtl/rot_aligner.sv
module rot_aligner
    import rot_align_pkg::*;
#(
    parameter int                 LOCK_RUN   = 8,
    parameter int                 LOSS_RUN   = 4,
    parameter logic [FRAME_W-1:0] TRAIN_WORD = 7'b1001011
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] in_word,
    input  logic               in_valid,
    input  logic               mode_train,
    input  logic [OFF_W-1:0]   static_rot,
    input  logic               train_req,
    output logic [FRAME_W-1:0] out_word,
    output logic               out_valid,
    output logic [OFF_W-1:0]   rot_used,
    output logic               locked,
    output logic               search_err
);

    align_mode_e        mode;
    logic [OFF_W-1:0]   cand;
    logic [OFF_W-1:0]   sel;
    logic [FRAME_W-1:0] slice;
    logic               pass;
    aligned_t           res;

    assign mode = align_mode_e'(mode_train);
    assign sel  = (mode == ALIGN_TRAIN) ? cand : clamp_off(static_rot);
    assign pass = (mode == ALIGN_STATIC) || locked;

    rot_window #(.W(FRAME_W), .OW(OFF_W)) u_window (
        .clk      (clk),
        .rst      (rst),
        .in_word  (in_word),
        .in_valid (in_valid),
        .sel      (sel),
        .slice    (slice)
    );

    rot_search #(
        .W          (FRAME_W),
        .OW         (OFF_W),
        .LOCK_RUN   (LOCK_RUN),
        .LOSS_RUN   (LOSS_RUN),
        .TRAIN_WORD (TRAIN_WORD)
    ) u_search (
        .clk       (clk),
        .rst       (rst),
        .active    (mode == ALIGN_TRAIN),
        .in_valid  (in_valid),
        .train_req (train_req),
        .slice     (slice),
        .cand      (cand),
        .locked    (locked),
        .err       (search_err)
    );

    rot_outreg u_out (
        .clk      (clk),
        .rst      (rst),
        .slice    (slice),
        .sel      (sel),
        .in_valid (in_valid),
        .pass     (pass),
        .q        (res)
    );

    assign out_word  = res.word;
    assign out_valid = res.valid;
    assign rot_used  = res.rot;

    // R2: the reported offset is always a legal slice position
    a_r2_rot_range: assert property (@(posedge clk) disable iff (rst)
        rot_used <= OFF_W'(FRAME_W - 1));

    // R3: static mode never reports lock or a sweep error
    a_r3_static_quiet: assert property (@(posedge clk) disable iff (rst)
        !mode_train |=> (!locked && !search_err));

    // R3: in static mode output valid tracks input valid one cycle later
    a_r3_static_valid: assert property (@(posedge clk) disable iff (rst)
        !mode_train |=> (out_valid == $past(in_valid)));

    // R6: an unlocked training link emits nothing
    a_r6_train_gate: assert property (@(posedge clk) disable iff (rst)
        (mode_train && !locked) |=> !out_valid);

    // R6: every output word stems from a valid input word
    a_r6_valid_source: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

endmodule

// File: tb/rot_aligner_bench.sv
module rot_aligner_bench;

    localparam logic [6:0] TW = 7'b1001011;

    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] in_word;
    logic       in_valid;
    logic       mode_train;
    logic [2:0] static_rot;
    logic       train_req;
    logic [6:0] out_word;
    logic       out_valid;
    logic [2:0] rot_used;
    logic       locked;
    logic       search_err;

    always #2.5 clk = ~clk;

    rot_aligner u_rot_aligner (
        .clk        (clk),
        .rst        (rst),
        .in_word    (in_word),
        .in_valid   (in_valid),
        .mode_train (mode_train),
        .static_rot (static_rot),
        .train_req  (train_req),
        .out_word   (out_word),
        .out_valid  (out_valid),
        .rot_used   (rot_used),
        .locked     (locked),
        .search_err (search_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state, updated from the requirements
    logic [6:0] m_prev, m_word;
    logic [2:0] m_cand, m_rot;
    logic       m_lock, m_err, m_oval;
    int         m_run, m_miss;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] rx_of(input logic [6:0] t_n, input logic [6:0] t_nx, input int c);
        logic [13:0] p;
        p = {t_n, t_nx} >> (7 - c);
        return p[6:0];
    endfunction

    task automatic model_reset();
        m_prev = '0; m_word = '0; m_cand = '0; m_rot = '0;
        m_lock = 0; m_err = 0; m_oval = 0; m_run = 0; m_miss = 0;
    endtask

    task automatic model_step(input logic v, input logic [6:0] w, input logic m,
                              input logic tr, input logic [2:0] s);
        logic [2:0]  off;
        logic [13:0] win;
        logic [6:0]  sl;
        off = m ? m_cand : ((s > 3'd6) ? 3'd6 : s);     // R3 clamp
        win = {m_prev, w} >> off;                        // R2 slice
        sl  = win[6:0];
        m_oval = v && (!m || m_lock);                    // R6 / R3
        if (v) begin
            m_word = sl; m_rot = off; m_prev = w;
        end
        if (!m) begin
            m_cand = 0; m_lock = 0; m_err = 0; m_run = 0; m_miss = 0;
        end else if (v && tr) begin
            if (!m_lock) begin                           // R4 / R5 / R7
                if (sl == TW) begin
                    if (m_run == 7) begin
                        m_lock = 1; m_run = 0; m_miss = 0; m_err = 0;
                    end else m_run++;
                end else begin
                    m_run = 0;
                    if (m_cand == 3'd6) begin m_cand = 0; m_err = 1; end
                    else m_cand++;
                end
            end else begin                               // R8
                if (sl == TW) m_miss = 0;
                else if (m_miss == 3) begin
                    m_lock = 0; m_cand = 0; m_run = 0; m_miss = 0;
                end else m_miss++;
            end
        end
    endtask

    task automatic compare_all();
        chk(out_word == m_word,   "R2 out_word",   out_word,   m_word);
        chk(rot_used == m_rot,    "R2 rot_used",   rot_used,   m_rot);
        chk(out_valid == m_oval,  "R6 out_valid",  out_valid,  m_oval);
        chk(locked == m_lock,     "R5 locked",     locked,     m_lock);
        chk(search_err == m_err,  "R7 search_err", search_err, m_err);
    endtask

    task automatic tick(input logic v, input logic [6:0] w, input logic m,
                        input logic tr, input logic [2:0] s);
        in_valid = v; in_word = w; mode_train = m; train_req = tr; static_rot = s;
        @(posedge clk);
        if (rst) model_reset(); else model_step(v, w, m, tr, s);
        @(negedge clk);
        compare_all();
    endtask

    // send n valid training words seen through link rotation c
    task automatic train_words(input int n, input int c);
        for (int i = 0; i < n; i++) tick(1'b1, rx_of(TW, TW, c), 1'b1, 1'b1, 3'd0);
    endtask

    task automatic go_static();
        tick(1'b0, 7'h00, 1'b0, 1'b0, 3'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] t_cur, t_nxt;
        void'($urandom(32'd1234));
        rst = 1'b1;
        in_valid = 0; in_word = 0; mode_train = 0; train_req = 0; static_rot = 0;
        @(negedge clk);
        tick(0, 7'h00, 0, 0, 3'd0);
        tick(0, 7'h00, 0, 0, 3'd0);
        rst = 1'b0;
        // R1: reset state
        chk(out_word == 0 && rot_used == 0 && !out_valid && !locked && !search_err,
            "R1 reset outputs", {out_word, rot_used, out_valid, locked, search_err}, 0);

        // R2/R3: every static offset recovers random transmitted words
        for (int c = 0; c < 8; c++) begin
            int ce;
            ce = (c > 6) ? 6 : c;
            t_cur = 7'($urandom);
            for (int i = 0; i < 20; i++) begin
                t_nxt = 7'($urandom);
                tick(1'b1, rx_of(t_cur, t_nxt, ce), 1'b0, 1'b0, 3'(c));
                if (i > 0) chk(out_word == t_cur, "R2 static recovers tx word", out_word, t_cur);
                t_cur = t_nxt;
            end
            chk(rot_used == 3'(ce), "R3 static offset clamp", rot_used, ce);
            tick(1'b0, 7'h55, 1'b0, 1'b0, 3'(c));
            chk(!out_valid && !locked, "R3 static valid follows input", out_valid, 0);
        end

        // R5: rotation 0 locks exactly on the 8th matching word
        go_static();
        train_words(7, 0);
        chk(!locked, "R5 not locked after 7 matches", locked, 0);
        train_words(1, 0);
        chk(locked, "R5 locked after 8 matches", locked, 1);
        train_words(1, 0);
        chk(out_valid && out_word == TW, "R6 valid word after lock", out_word, TW);

        // R10: order 2,1,0,6,5,4,3 locks at offset 4
        go_static();
        chk(rx_of(TW, TW, 4) == {TW[2:0], TW[6:3]}, "R10 stream order", rx_of(TW, TW, 4), {TW[2:0], TW[6:3]});
        train_words(20, 4);
        chk(locked && rot_used == 3'd4, "R10 lock offset", rot_used, 4);
        chk(out_word == TW, "R10 aligned word", out_word, TW);

        // R4: every rotation is found
        for (int c = 0; c < 7; c++) begin
            go_static();
            train_words(7 + 8 + 2, c);
            chk(locked && rot_used == 3'(c), "R4 search finds offset", rot_used, c);
        end

        // R9: garbage without training request leaves lock alone
        go_static();
        train_words(20, 3);
        for (int i = 0; i < 20; i++) tick(1'b1, 7'($urandom), 1'b1, 1'b0, 3'd0);
        chk(locked && rot_used == 3'd3, "R9 lock held without request", rot_used, 3);

        // R8: drift after lock drops lock on the 4th mismatch, then relocks
        train_words(3, 5);
        chk(locked, "R8 still locked after 3 misses", locked, 1);
        train_words(1, 5);
        chk(!locked, "R8 unlocked after 4 misses", locked, 0);
        train_words(20, 5);
        chk(locked && rot_used == 3'd5, "R8 relock on new offset", rot_used, 5);

        // R7: unmatchable stream raises error and keeps searching
        go_static();
        train_words(7, 0);      // seed window
        for (int i = 0; i < 10; i++) tick(1'b1, 7'h00, 1'b1, 1'b1, 3'd0);
        chk(search_err && !locked, "R7 sweep error raised", search_err, 1);
        train_words(20, 2);
        chk(locked && !search_err, "R7 error cleared on lock", search_err, 0);

        // random mix
        for (int seg = 0; seg < 40; seg++) begin
            int c;
            logic m;
            c = int'($urandom % 7);
            m = ($urandom % 4) != 0;
            for (int i = 0; i < 60; i++) begin
                logic v, tr;
                logic [6:0] w;
                v  = ($urandom % 5) != 0;
                tr = ($urandom % 6) != 0;
                w  = (($urandom % 12) == 0) ? 7'($urandom) : rx_of(TW, TW, c);
                tick(v, w, m, tr, 3'($urandom));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule